// File: doc/BRIEF.md
# I2C Target with Clock Stretching

This block is a 7-bit-address I2C target. The system clock oversamples it, and it drives SCL and SDA as open-drain pull-down enables. Both bus lines pass through a two-flop synchronizer. From the settled levels the block finds SCL edges, Start conditions (SDA falls while SCL is high) and Stop conditions (SDA rises while SCL is high). A byte-wide shift register collects the address byte. When the upper seven bits equal `ownAddr`, the target acknowledges, copies the byte into a single host-visible buffer and records the direction from the byte's least significant bit.

A host-side controller works the block through a handful of pulses and flags. It reads the buffer, writes transmit data, clears the interrupt and overflow flags, and releases a stretched clock. The block pulls SCL low after a read address, and after every transmitted byte the controller acknowledges. After received bytes it pulls SCL low only when `stretchEn` is set. In every case SCL stays low until the host pulses `relStb`. A received byte is refused with a NACK when the buffer-full or overflow flag is already set. A byte that arrives while the buffer is still full raises the overflow flag.

Top module: `i2cTgt`

## Requirements
- R1: After reset both bus enables (`sclOe`, `sdaOe`) are low and `irqFlag`, `bufFull` and `ovfFlag` are 0.
- R2: A Stop returns the target to idle from any state, including part-way through an address byte. A later Start begins a fresh address byte.
- R3: A write address (byte = {ownAddr, 0}) that matches is acknowledged (SDA low in the ninth clock) while both flags are clear. The byte is loaded into `bufRdData`, `rwFlag` goes to 0, and `bufFull` and `irqFlag` are set.
- R4: A mismatching address gets no acknowledge. Every later byte up to the next Start is also left unacknowledged and changes no flag or buffer.
- R5: A matching address is not acknowledged if `bufFull` or `ovfFlag` is already set. `ovfFlag` is set when `bufFull` was the cause.
- R6: Each received data byte is acknowledged, loaded into the buffer, and sets `bufFull` and `irqFlag`.
- R7: A data byte that completes while `bufFull` is set gets a NACK, sets `ovfFlag` and leaves the buffer unchanged. A `bufRdEn` pulse clears `bufFull`. Only an `ovfClr` pulse clears `ovfFlag`.
- R8: In receive direction with `stretchEn`=1, `sclOe` goes high after the ninth clock of each byte and stays high until a `relStb` pulse. With `stretchEn`=0 it stays low.
- R9: A read address (byte = {ownAddr, 1}) that matches is acknowledged, loaded into the buffer and sets `rwFlag`=1. SCL is then held low regardless of `stretchEn` until `relStb`.
- R10: In transmit direction a `bufWrEn` while SCL is held loads the shift register. The bits leave MSB first, and SDA changes only while SCL is low.
- R11: The controller's acknowledge is sampled on the ninth rising SCL edge, and `irqFlag` is set at the ninth falling edge. On ACK the target holds SCL again for the next byte. On NACK it releases both lines and waits for a Start.
- R12: Once set, `irqFlag` stays set through any bus traffic until an `irqClr` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Sensed SCL bus level |
| sdaIn | input | 1 | Sensed SDA bus level |
| sclOe | output | 1 | 1 pulls SCL low (clock stretch) |
| sdaOe | output | 1 | 1 pulls SDA low |
| ownAddr | input | 7 | Target address |
| stretchEn | input | 1 | Stretch after received bytes |
| relStb | input | 1 | Host pulse releasing a held SCL |
| bufWrEn | input | 1 | Host write strobe for the data buffer |
| bufWrData | input | 8 | Host write data (transmit byte) |
| bufRdEn | input | 1 | Host read acknowledge, clears buffer-full |
| bufRdData | output | 8 | Data buffer contents |
| irqClr | input | 1 | Clears the per-byte interrupt flag |
| ovfClr | input | 1 | Clears the overflow flag |
| irqFlag | output | 1 | Per-byte interrupt flag |
| rwFlag | output | 1 | Direction of the last matched address (1 = read) |
| bufFull | output | 1 | Buffer holds an unread received byte |
| ovfFlag | output | 1 | Byte refused because the buffer was full |

## Verification
The bench drives an open-drain controller model. It waits for SCL to rise before continuing, so a design that never releases a stretch shows up as a hang, and one that never stretches shows up as `sclOe` being low at the hold checks. A byte sent with the buffer still full must produce a NACK, set overflow and keep the old buffer value. A design that loads anyway, or acknowledges anyway, fails the buffer or ack comparison. The read sequence checks that the data arrives MSB first, that SCL is held again after an ACK, and that the lines are released after a NACK. An abandoned address followed by a fresh Start must still be acknowledged, which catches a design that does not reset on Stop. Traffic after an address mismatch must leave every flag untouched.

// File: rtl/i2cTgtPkg.sv
package i2cTgtPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_IGNORE
  } tgtState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;   // capture SDA into shift register
    logic shiftOut;  // advance transmit bit
    logic loadBuf;   // copy shift register into buffer, set buffer-full
    logic setOvf;
    logic setIrq;
    logic setRw;
    logic rwVal;
    logic txArmed;   // transmit shift register may be loaded by host
  } dpStrobe_t;

endpackage

// File: rtl/i2cTgtSync.sv
module i2cTgtSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  logic [1:0] rawLine;
  logic [1:0] lvl;
  logic sclPrev, sdaPrev;

  assign rawLine = {sdaIn, sclIn};

  generate
    for (genvar g = 0; g < 2; g++) begin : gLine
      logic [STAGES-1:0] stg;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg <= '1;
        else       stg <= {stg[STAGES-2:0], rawLine[g]};
      end
      assign lvl[g] = stg[STAGES-1];
    end
  endgenerate

  assign sclLvl = lvl[0];
  assign sdaLvl = lvl[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclLvl;
      sdaPrev <= sdaLvl;
    end
  end

  assign sclRise  = sclLvl & ~sclPrev;
  assign sclFall  = ~sclLvl & sclPrev;
  assign startDet = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopDet  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;

endmodule

// File: rtl/i2cTgtData.sv
module i2cTgtData
  import i2cTgtPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic              sdaBit,
  input  logic              bufWrEn,
  input  logic [DATA_W-1:0] bufWrData,
  input  logic              bufRdEn,
  input  logic              irqClr,
  input  logic              ovfClr,
  output logic [DATA_W-1:0] shiftByte,
  output logic              txBit,
  output logic [DATA_W-1:0] bufData,
  output logic              bufFull,
  output logic              ovfFlag,
  output logic              irqFlag,
  output logic              rwFlag
);

  logic [DATA_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (bufWrEn && stb.txArmed) begin
      shiftReg <= bufWrData;
    end else if (stb.shiftIn) begin
      shiftReg <= {shiftReg[DATA_W-2:0], sdaBit};
    end else if (stb.shiftOut) begin
      shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufData <= '0;
      bufFull <= 1'b0;
      ovfFlag <= 1'b0;
      irqFlag <= 1'b0;
      rwFlag  <= 1'b0;
    end else begin
      if (stb.loadBuf)  bufData <= shiftReg;
      else if (bufWrEn) bufData <= bufWrData;

      if (stb.loadBuf)  bufFull <= 1'b1;
      else if (bufRdEn) bufFull <= 1'b0;

      if (stb.setOvf)   ovfFlag <= 1'b1;
      else if (ovfClr)  ovfFlag <= 1'b0;

      if (stb.setIrq)   irqFlag <= 1'b1;
      else if (irqClr)  irqFlag <= 1'b0;

      if (stb.setRw)    rwFlag  <= stb.rwVal;
    end
  end

  assign shiftByte = shiftReg;
  assign txBit     = shiftReg[DATA_W-1];

  // R12: interrupt flag persists until the host clears it
  assert_irq_sticky_R12: assert property (@(posedge clk) disable iff (!rstN)
    ($past(irqFlag) && !$past(irqClr)) |-> irqFlag);

  // R7: overflow only falls through an explicit clear
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ovfFlag) && !$past(ovfClr)) |-> ovfFlag);

  // R7: a host read empties the buffer unless a byte landed at once
  assert_read_empties_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(bufRdEn) && !$past(stb.loadBuf)) |-> !bufFull);

endmodule

// File: rtl/i2cTgtCtrl.sv
module i2cTgtCtrl
  import i2cTgtPkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclLvl,
  input  logic              sdaLvl,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              stretchEn,
  input  logic              relStb,
  input  logic [DATA_W-1:0] shiftByte,
  input  logic              txBit,
  input  logic              bufFull,
  input  logic              ovfFlag,
  output dpStrobe_t         stb,
  output logic              sclOe,
  output logic              sdaOe
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DATA_W);

  tgtState_e st, stN;
  logic [CNT_W-1:0] bitCnt, cntN;
  logic ackDrv, ackN;
  logic sclHold, holdN;
  logic isRead, readN;
  logic nackSeen, nackN;
  logic addrHit, refuse;

  assign addrHit = (shiftByte[DATA_W-1 -: ADDR_W] == ownAddr);
  assign refuse  = bufFull | ovfFlag;

  always_comb begin
    stN   = st;
    cntN  = bitCnt;
    ackN  = ackDrv;
    holdN = sclHold & ~relStb;
    readN = isRead;
    nackN = nackSeen;
    stb   = '0;
    stb.txArmed = (st == ST_TX) && (bitCnt == '0);
    if (stopDet) begin
      stN   = ST_IDLE;
      ackN  = 1'b0;
      holdN = 1'b0;
    end else if (startDet) begin
      stN   = ST_ADDR;
      cntN  = '0;
      ackN  = 1'b0;
      holdN = 1'b0;
    end else begin
      unique case (st)
        ST_ADDR, ST_RX: begin
          if (sclRise && bitCnt != FULL_CNT) begin
            stb.shiftIn = 1'b1;
            cntN = bitCnt + 1'b1;
          end
          if (sclFall && bitCnt == FULL_CNT) begin
            if (st == ST_ADDR) begin
              if (!addrHit) begin
                stN = ST_IGNORE;
              end else if (refuse) begin
                stN = ST_IGNORE;
                stb.setOvf = bufFull;
              end else begin
                stN = ST_ADDR_ACK;
                ackN = 1'b1;
                stb.loadBuf = 1'b1;
                stb.setIrq  = 1'b1;
                stb.setRw   = 1'b1;
                stb.rwVal   = shiftByte[0];
                readN       = shiftByte[0];
              end
            end else begin
              stN = ST_RX_ACK;
              stb.setIrq = 1'b1;
              if (refuse) begin
                stb.setOvf = bufFull;
              end else begin
                ackN = 1'b1;
                stb.loadBuf = 1'b1;
              end
            end
          end
        end
        ST_ADDR_ACK, ST_RX_ACK: begin
          if (sclFall) begin
            ackN = 1'b0;
            cntN = '0;
            if (st == ST_ADDR_ACK && isRead) begin
              stN   = ST_TX;
              holdN = 1'b1;
            end else begin
              stN   = ST_RX;
              holdN = stretchEn;
            end
          end
        end
        ST_TX: begin
          if (sclRise && bitCnt != FULL_CNT) cntN = bitCnt + 1'b1;
          if (sclFall) begin
            if (bitCnt == FULL_CNT) stN = ST_TX_ACK;
            else if (bitCnt != '0)  stb.shiftOut = 1'b1;
          end
        end
        ST_TX_ACK: begin
          if (sclRise) nackN = sdaLvl;
          if (sclFall) begin
            stb.setIrq = 1'b1;
            cntN = '0;
            if (nackSeen) begin
              stN = ST_IDLE;
            end else begin
              stN   = ST_TX;
              holdN = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      bitCnt   <= '0;
      ackDrv   <= 1'b0;
      sclHold  <= 1'b0;
      isRead   <= 1'b0;
      nackSeen <= 1'b0;
    end else begin
      st       <= stN;
      bitCnt   <= cntN;
      ackDrv   <= ackN;
      sclHold  <= holdN;
      isRead   <= readN;
      nackSeen <= nackN;
    end
  end

  assign sclOe = sclHold;
  assign sdaOe = (((st == ST_ADDR_ACK) || (st == ST_RX_ACK)) && ackDrv) ||
                 ((st == ST_TX) && !txBit);

  // R10: SDA driven by the target never moves while SCL is high
  assert_sda_steady_high_R10: assert property (@(posedge clk) disable iff (!rstN)
    (sclLvl && $past(sclLvl) && !$past(startDet) && !$past(stopDet)) |-> $stable(sdaOe));

  // R8: a held clock is kept until the host releases it
  assert_hold_until_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    (sclOe && !relStb && !startDet && !stopDet) |=> sclOe);

  // R9: a read address always ends in a held clock
  assert_read_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_ADDR_ACK && isRead && sclFall && !startDet && !stopDet) |=> sclOe);

  // R5: a refused address leaves SDA released
  assert_refuse_nack_R5: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_ADDR && sclFall && bitCnt == FULL_CNT && refuse && !startDet && !stopDet)
      |=> !sdaOe);

endmodule

// File: rtl/i2cTgt.sv
module i2cTgt
  import i2cTgtPkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              stretchEn,
  input  logic              relStb,
  input  logic              bufWrEn,
  input  logic [DATA_W-1:0] bufWrData,
  input  logic              bufRdEn,
  output logic [DATA_W-1:0] bufRdData,
  input  logic              irqClr,
  input  logic              ovfClr,
  output logic              irqFlag,
  output logic              rwFlag,
  output logic              bufFull,
  output logic              ovfFlag
);

  logic sclLvl, sdaLvl, sclRise, sclFall, startDet, stopDet;
  logic [DATA_W-1:0] shiftByte;
  logic txBit;
  dpStrobe_t stb;

  i2cTgtSync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  i2cTgtCtrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sclLvl(sclLvl), .sdaLvl(sdaLvl),
    .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
    .ownAddr(ownAddr), .stretchEn(stretchEn), .relStb(relStb),
    .shiftByte(shiftByte), .txBit(txBit), .bufFull(bufFull), .ovfFlag(ovfFlag),
    .stb(stb), .sclOe(sclOe), .sdaOe(sdaOe)
  );

  i2cTgtData #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaBit(sdaLvl),
    .bufWrEn(bufWrEn), .bufWrData(bufWrData), .bufRdEn(bufRdEn),
    .irqClr(irqClr), .ovfClr(ovfClr),
    .shiftByte(shiftByte), .txBit(txBit), .bufData(bufRdData),
    .bufFull(bufFull), .ovfFlag(ovfFlag), .irqFlag(irqFlag), .rwFlag(rwFlag)
  );

endmodule

// File: tb/test_i2cTgt.sv
`timescale 1ns/1ps
module test_i2cTgt;

  localparam int H = 8;  // clocks per SCL phase
  localparam logic [6:0] MY_ADDR = 7'h2A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic sclOe, sdaOe;
  logic stretchEn = 1'b0, relStb = 1'b0;
  logic bufWrEn = 1'b0, bufRdEn = 1'b0, irqClr = 1'b0, ovfClr = 1'b0;
  logic [7:0] bufWrData = '0;
  logic [7:0] bufRdData;
  logic irqFlag, rwFlag, bufFull, ovfFlag;
  logic busScl, busSda;

  int nChk = 0;
  int nFail = 0;

  // reference model state
  logic [7:0] expBuf = '0;
  logic expFull = 1'b0, expOvf = 1'b0, expIrq = 1'b0, expRw = 1'b0;

  always #10 clk = ~clk;

  assign busScl = mScl & ~sclOe;
  assign busSda = mSda & ~sdaOe;

  i2cTgt i_i2cTgt (
    .clk(clk), .rstN(rstN), .sclIn(busScl), .sdaIn(busSda),
    .sclOe(sclOe), .sdaOe(sdaOe), .ownAddr(MY_ADDR), .stretchEn(stretchEn),
    .relStb(relStb), .bufWrEn(bufWrEn), .bufWrData(bufWrData), .bufRdEn(bufRdEn),
    .bufRdData(bufRdData), .irqClr(irqClr), .ovfClr(ovfClr),
    .irqFlag(irqFlag), .rwFlag(rwFlag), .bufFull(bufFull), .ovfFlag(ovfFlag)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chkModel(input string tag);
    chk({tag, " buffer"},   {24'd0, bufRdData}, {24'd0, expBuf});
    chk({tag, " bufFull"},  {31'd0, bufFull},   {31'd0, expFull});
    chk({tag, " ovfFlag"},  {31'd0, ovfFlag},   {31'd0, expOvf});
    chk({tag, " irqFlag"},  {31'd0, irqFlag},   {31'd0, expIrq});
    chk({tag, " rwFlag"},   {31'd0, rwFlag},    {31'd0, expRw});
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitSclHigh();
    int t = 0;
    while (!busScl && t < 20000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic pulseRd();  bufRdEn = 1'b1; tick(1); bufRdEn = 1'b0; tick(1); expFull = 1'b0; endtask
  task automatic pulseIrq(); irqClr  = 1'b1; tick(1); irqClr  = 1'b0; tick(1); expIrq  = 1'b0; endtask
  task automatic pulseOvf(); ovfClr  = 1'b1; tick(1); ovfClr  = 1'b0; tick(1); expOvf  = 1'b0; endtask
  task automatic pulseRel(); relStb  = 1'b1; tick(1); relStb  = 1'b0; tick(2); endtask
  task automatic hostWrite(input logic [7:0] d);
    bufWrData = d; bufWrEn = 1'b1; tick(1); bufWrEn = 1'b0; tick(1); expBuf = d;
  endtask

  task automatic busStart();
    mSda = 1'b1; tick(H);
    mScl = 1'b1; waitSclHigh(); tick(H);
    mSda = 1'b0; tick(H);
    mScl = 1'b0; tick(H);
  endtask

  task automatic busStop();
    mSda = 1'b0; tick(H);
    mScl = 1'b1; waitSclHigh(); tick(H);
    mSda = 1'b1; tick(H);
  endtask

  task automatic sendBit(input logic b);
    mSda = b; tick(H);
    mScl = 1'b1; waitSclHigh(); tick(H);
    mScl = 1'b0; tick(H);
  endtask

  task automatic writeByte(input logic [7:0] d, output logic ackLvl);
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    mSda = 1'b1; tick(H);
    mScl = 1'b1; waitSclHigh(); tick(H);
    ackLvl = busSda;
    mScl = 1'b0; tick(H);
  endtask

  task automatic readByte(input logic ackBit, output logic [7:0] d);
    d = '0;
    for (int i = 0; i < 8; i++) begin
      mSda = 1'b1; tick(H);
      mScl = 1'b1; waitSclHigh(); tick(H);
      d = {d[6:0], busSda};
      mScl = 1'b0; tick(H);
    end
    mSda = ackBit; tick(H);
    mScl = 1'b1; waitSclHigh(); tick(H);
    mScl = 1'b0; tick(H);
    mSda = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] rd;
    tick(5);
    rstN = 1'b1;
    tick(5);

    // R1 reset state
    chk("R1 sclOe", {31'd0, sclOe}, 0);
    chk("R1 sdaOe", {31'd0, sdaOe}, 0);
    chkModel("R1");

    // R3 write address acknowledged
    busStart();
    writeByte({MY_ADDR, 1'b0}, ack);
    expBuf = {MY_ADDR, 1'b0}; expFull = 1; expIrq = 1; expRw = 0;
    chk("R3 ack", {31'd0, ack}, 0);
    chkModel("R3");
    pulseRd(); pulseIrq();
    chk("R7 read clears bufFull", {31'd0, bufFull}, 0);

    // R6 data bytes, no stretch (R8)
    writeByte(8'hA5, ack);
    expBuf = 8'hA5; expFull = 1; expIrq = 1;
    chk("R6 ack", {31'd0, ack}, 0);
    chk("R8 no stretch when disabled", {31'd0, sclOe}, 0);
    chkModel("R6");
    pulseRd(); pulseIrq();
    writeByte(8'h3C, ack);
    expBuf = 8'h3C; expFull = 1; expIrq = 1;
    chk("R6 second ack", {31'd0, ack}, 0);
    chkModel("R6 second");

    // R7 overflow: buffer not read
    writeByte(8'h77, ack);
    expOvf = 1;
    chk("R7 overflow nack", {31'd0, ack}, 1);
    chkModel("R7 overflow");
    pulseRd();
    chkModel("R7 after read");
    busStop();

    // R5 address refused while overflow set
    pulseIrq();
    busStart();
    writeByte({MY_ADDR, 1'b0}, ack);
    chk("R5 refused nack", {31'd0, ack}, 1);
    chkModel("R5");
    busStop();
    pulseOvf();
    chk("R7 ovfClr clears", {31'd0, ovfFlag}, 0);

    // R4 mismatch ignored until next Start
    busStart();
    writeByte({7'h11, 1'b0}, ack);
    chk("R4 mismatch nack", {31'd0, ack}, 1);
    writeByte(8'h00, ack);
    chk("R4 later byte nack", {31'd0, ack}, 1);
    chkModel("R4");
    busStop();

    // R2 Stop part-way through an address
    busStart();
    sendBit(1'b0); sendBit(1'b1); sendBit(1'b0);
    busStop();
    chk("R2 idle sdaOe", {31'd0, sdaOe}, 0);
    chkModel("R2 idle");
    busStart();
    writeByte({MY_ADDR, 1'b0}, ack);
    expBuf = {MY_ADDR, 1'b0}; expFull = 1; expIrq = 1; expRw = 0;
    chk("R2 fresh address ack", {31'd0, ack}, 0);
    chkModel("R2 fresh");
    pulseRd(); pulseIrq();

    // R8 stretch after a received byte
    stretchEn = 1'b1;
    writeByte(8'h5A, ack);
    expBuf = 8'h5A; expFull = 1; expIrq = 1;
    chk("R8 ack", {31'd0, ack}, 0);
    chk("R8 held after byte", {31'd0, sclOe}, 1);
    pulseRd();
    tick(20);
    chk("R8 still held", {31'd0, sclOe}, 1);
    pulseRel();
    chk("R8 released", {31'd0, sclOe}, 0);
    pulseIrq();
    stretchEn = 1'b0;
    busStop();

    // R9 read address, R10 transmit, R11 controller acknowledge
    busStart();
    writeByte({MY_ADDR, 1'b1}, ack);
    expBuf = {MY_ADDR, 1'b1}; expFull = 1; expIrq = 1; expRw = 1;
    chk("R9 ack", {31'd0, ack}, 0);
    chk("R9 held regardless of stretchEn", {31'd0, sclOe}, 1);
    chkModel("R9");
    pulseRd(); pulseIrq();
    hostWrite(8'hC3);
    pulseRel();
    readByte(1'b0, rd);
    expIrq = 1;
    chk("R10 first byte", {24'd0, rd}, 32'hC3);
    chk("R11 irq at ninth fall", {31'd0, irqFlag}, 1);
    chk("R11 held after ACK", {31'd0, sclOe}, 1);
    pulseIrq();
    hostWrite(8'h96);
    pulseRel();
    readByte(1'b1, rd);
    expIrq = 1;
    chk("R10 second byte", {24'd0, rd}, 32'h96);
    chk("R11 scl free after NACK", {31'd0, sclOe}, 0);
    chk("R11 sda free after NACK", {31'd0, sdaOe}, 0);
    chkModel("R11");
    busStop();

    // R12 flag survives unrelated traffic
    busStart();
    writeByte({7'h33, 1'b1}, ack);
    busStop();
    chk("R12 irq kept", {31'd0, irqFlag}, 1);
    pulseIrq();
    chk("R12 irq cleared by host", {31'd0, irqFlag}, 0);

    tick(10);
    summary();
    $finish;
  end

endmodule